// File: doc/BRIEF.md
# Calendar Counter Real-Time Clock

A memory-mapped real-time clock. It keeps time of day as one packed 32-bit word (day count, hour, minute, second) and advances it from a slow timekeeping enable that the system supplies at 32768 Hz. The enable is divided down into half-second and second boundaries. On each second the block compares the new hour, minute and second against a programmed alarm time. A match latches an alarm event, which can drive an interrupt and a wakeup output.

Periodic events at day, hour, minute, second and half-second boundaries latch into status bits of their own, and each one can be routed to the interrupt. Software writes to the counter, alarm, control and trim registers land in shadow copies first. Each copy reaches the slow domain only at the next slow tick. A write-done status flag lets software poll until every earlier write has landed, so it can order a counter load before an enable, or an alarm change before re-arming.

The slow domain is modelled as a clock enable inside the bus clock domain, so the handshake stays cycle-exact and no clock crossing is needed.

Top module: `rtc_cal_top`

## Requirements
- R1: Offset 0x00 reads 0x030110 in bits 31:8 and the REV parameter in bits 7:0. Offset 0x04 and any other unmapped offset read 0.
- R2: A write to the counter (0x10), alarm (0x14), control (0x18) or trim (0x20) register clears write-done (status bit 16) from the next cycle. Write-done returns to 1 at the first slow tick with no write in the same cycle, so it is back within one tick period plus two cycles.
- R3: A write to the counter, alarm, control or trim register takes effect only at the next slow tick. Until then a read returns the previous value. Control keeps bits 7:0 only, and its bits 31:8 read 0.
- R4: The counter word holds seconds in bits 5:0, minutes in 11:6, hours in 16:12 and days in 31:17. It advances only while control bit 0 is 1. A half-second event occurs every HALF_DIV slow ticks, and every second half-second event adds one second.
- R5: Seconds wrap from 59 to 0 and carry into minutes. Minutes wrap from 59 to 0 and carry into hours. Hours wrap from 23 to 0 and carry into the day count. The day count wraps from 0x7FFF to 0.
- R6: A counter load, applied at a slow tick, restarts the half-second divider and the second phase. The first second boundary after the load falls 2*HALF_DIV ticks later.
- R7: When a second step makes hour, minute and second equal the alarm's, status bit 2 sets. The alarm's day field (bits 31:17) takes no part in the comparison.
- R8: Periodic events latch in status bit 3 (day), 4 (hour), 5 (minute), 6 (second) and 7 (half-second).
- R9: Writing 1 to a bit of the status register (0x1C) clears that bit. Writing 0 leaves it unchanged, and a new event in the same cycle wins over the clear. A status write does not clear write-done.
- R10: irq_o is 1 exactly when some status bit 7..2 is set and the control bit at the same position is set.
- R11: wake_o is 1 exactly when status bit 2 and control bit 1 are both set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slow_tick_i | input | 1 | One-cycle timekeeping enable pulse (32768 Hz) |
| sel_i | input | 1 | Bus access this cycle |
| we_i | input | 1 | 1 for write, 0 for read |
| addr_i | input | ADDR_W | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, valid in the same cycle |
| irq_o | output | 1 | Level interrupt |
| wake_o | output | 1 | Alarm wakeup request |

## Verification
A wrong pending flag or shadow value shows in two ways at the next status or register read. Write-done stays low past one tick period, or the old register value is still visible after the tick that should have applied the new one. A wrong divider or carry moves a second, minute or day boundary by at least one tick. Comparing the counter read every few cycles, and irq_o and wake_o on every cycle, against a behavioural model exposes such a shift at the cycle it happens. A mis-gated event or enable appears on irq_o or wake_o in the cycle after the offending slow tick.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int unsigned NSLOT = 4;
  localparam int unsigned SLOT_CNT = 0;
  localparam int unsigned SLOT_ALM = 1;
  localparam int unsigned SLOT_CTL = 2;
  localparam int unsigned SLOT_TRM = 3;

  localparam int unsigned EV_W = 6;  // status/control bits 7..2

  localparam logic [7:0] OFF_ID  = 8'h00;
  localparam logic [7:0] OFF_CNT = 8'h10;
  localparam logic [7:0] OFF_ALM = 8'h14;
  localparam logic [7:0] OFF_CTL = 8'h18;
  localparam logic [7:0] OFF_STA = 8'h1C;
  localparam logic [7:0] OFF_TRM = 8'h20;

  localparam logic [23:0] ID_CODE = 24'h030110;

  typedef struct packed {
    logic [14:0] day;
    logic [4:0]  hour;
    logic [5:0]  min;
    logic [5:0]  sec;
  } tod_t;

  function automatic logic [7:0] slot_off(int unsigned s);
    case (s)
      SLOT_CNT: return OFF_CNT;
      SLOT_ALM: return OFF_ALM;
      SLOT_CTL: return OFF_CTL;
      default:  return OFF_TRM;
    endcase
  endfunction

  function automatic logic [31:0] slot_mask(int unsigned s);
    return (s == SLOT_CTL) ? 32'h0000_00FF : 32'hFFFF_FFFF;
  endfunction
endpackage

// File: rtl/rtc_cal_regs.sv
module rtc_cal_regs import rtc_cal_pkg::*; #(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic              cnt_ld_o,
  output logic [31:0]       cnt_val_o,
  output logic [31:0]       alm_o,
  output logic [31:0]       ctl_o,
  output logic [31:0]       trm_o,
  output logic              done_o
);
  logic [NSLOT-1:0] hit;
  logic [NSLOT-1:0] pend_v;
  logic             pend_q   [NSLOT];
  logic [31:0]      shadow_q [NSLOT];
  logic [31:0]      live_q   [1:NSLOT-1];

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    assign hit[s]    = wr_i && (addr_i == ADDR_W'(slot_off(s)));
    assign pend_v[s] = pend_q[s];

    // a write in a tick cycle stays pending for the following tick
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_q[s]   <= 1'b0;
        shadow_q[s] <= '0;
      end else if (hit[s]) begin
        pend_q[s]   <= 1'b1;
        shadow_q[s] <= wdata_i & slot_mask(s);
      end else if (tick_i) begin
        pend_q[s]   <= 1'b0;
      end
    end

    if (s != SLOT_CNT) begin : g_live
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                 live_q[s] <= '0;
        else if (tick_i && pend_q[s]) live_q[s] <= shadow_q[s];
      end
    end
  end

  assign cnt_ld_o  = tick_i && pend_q[SLOT_CNT];
  assign cnt_val_o = shadow_q[SLOT_CNT];
  assign alm_o     = live_q[SLOT_ALM];
  assign ctl_o     = live_q[SLOT_CTL];
  assign trm_o     = live_q[SLOT_TRM];
  assign done_o    = ~|pend_v;
endmodule

// File: rtl/rtc_cal_prescale.sv
module rtc_cal_prescale #(
  parameter int unsigned HALF_DIV = 16384
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic run_i,
  input  logic restart_i,
  output logic hsec_o,
  output logic sec_o
);
  localparam int unsigned PW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(HALF_DIV - 1);

  logic [PW-1:0] div_q;
  logic          phase_q;
  logic          step, wrap;

  assign step   = tick_i && run_i && !restart_i;
  assign wrap   = (div_q == LAST);
  assign hsec_o = step && wrap;
  assign sec_o  = hsec_o && phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q   <= '0;
      phase_q <= 1'b0;
    end else if (restart_i) begin
      div_q   <= '0;
      phase_q <= 1'b0;
    end else if (step) begin
      if (wrap) begin
        div_q   <= '0;
        phase_q <= !phase_q;
      end else begin
        div_q   <= div_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rtc_cal_tod.sv
module rtc_cal_tod import rtc_cal_pkg::*; (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        load_i,
  input  tod_t        load_val_i,
  input  logic        step_i,
  input  logic [16:0] alm_hms_i,
  output tod_t        tod_o,
  output logic        min_ev_o,
  output logic        hour_ev_o,
  output logic        day_ev_o,
  output logic        alm_ev_o
);
  tod_t cur_q, nxt;
  logic sec_wrap, min_wrap, hour_wrap;

  assign sec_wrap  = (cur_q.sec  == 6'd59);
  assign min_wrap  = (cur_q.min  == 6'd59);
  assign hour_wrap = (cur_q.hour == 5'd23);

  always_comb begin
    nxt = cur_q;
    if (!sec_wrap) begin
      nxt.sec = cur_q.sec + 6'd1;
    end else begin
      nxt.sec = '0;
      if (!min_wrap) begin
        nxt.min = cur_q.min + 6'd1;
      end else begin
        nxt.min = '0;
        if (!hour_wrap) begin
          nxt.hour = cur_q.hour + 5'd1;
        end else begin
          nxt.hour = '0;
          nxt.day  = cur_q.day + 15'd1;  // wraps at 0x7FFF
        end
      end
    end
  end

  assign min_ev_o  = step_i && sec_wrap;
  assign hour_ev_o = min_ev_o && min_wrap;
  assign day_ev_o  = hour_ev_o && hour_wrap;
  assign alm_ev_o  = step_i && ({nxt.hour, nxt.min, nxt.sec} == alm_hms_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cur_q <= '0;
    else if (load_i)  cur_q <= load_val_i;
    else if (step_i)  cur_q <= nxt;
  end

  assign tod_o = cur_q;
endmodule

// File: rtl/rtc_cal_status.sv
module rtc_cal_status import rtc_cal_pkg::*; (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [EV_W-1:0] ev_i,
  input  logic            clr_i,
  input  logic [EV_W-1:0] clr_mask_i,
  input  logic [EV_W-1:0] ien_i,
  output logic [EV_W-1:0] sta_o,
  output logic            irq_o
);
  logic [EV_W-1:0] sta_q;

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sta_q <= '0;
    else         sta_q <= (sta_q & ~({EV_W{clr_i}} & clr_mask_i)) | ev_i;
  end

  assign sta_o = sta_q;
  assign irq_o = |(sta_q & ien_i);
endmodule

// File: rtl/rtc_cal_top.sv
module rtc_cal_top import rtc_cal_pkg::*; #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned HALF_DIV = 16384,
  parameter logic [7:0]  REV      = 8'h01
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slow_tick_i,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o,
  output logic              wake_o
);
  logic            bus_wr, sta_wr;
  logic            cnt_ld, write_done;
  logic [31:0]     cnt_val, alm_q, ctl_q, trm_q;
  logic            hsec_ev, sec_ev, min_ev, hour_ev, day_ev, alm_ev;
  logic [EV_W-1:0] ev, sta;
  tod_t            tod;

  assign bus_wr = sel_i && we_i;
  assign sta_wr = bus_wr && (addr_i == ADDR_W'(OFF_STA));

  rtc_cal_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni,
    .tick_i    (slow_tick_i),
    .wr_i      (bus_wr),
    .addr_i,
    .wdata_i,
    .cnt_ld_o  (cnt_ld),
    .cnt_val_o (cnt_val),
    .alm_o     (alm_q),
    .ctl_o     (ctl_q),
    .trm_o     (trm_q),
    .done_o    (write_done)
  );

  rtc_cal_prescale #(.HALF_DIV(HALF_DIV)) u_pre (
    .clk_i, .rst_ni,
    .tick_i    (slow_tick_i),
    .run_i     (ctl_q[0]),
    .restart_i (cnt_ld),
    .hsec_o    (hsec_ev),
    .sec_o     (sec_ev)
  );

  rtc_cal_tod u_tod (
    .clk_i, .rst_ni,
    .load_i     (cnt_ld),
    .load_val_i (tod_t'(cnt_val)),
    .step_i     (sec_ev),
    .alm_hms_i  (alm_q[16:0]),
    .tod_o      (tod),
    .min_ev_o   (min_ev),
    .hour_ev_o  (hour_ev),
    .day_ev_o   (day_ev),
    .alm_ev_o   (alm_ev)
  );

  assign ev = {hsec_ev, sec_ev, min_ev, hour_ev, day_ev, alm_ev};

  rtc_cal_status u_sta (
    .clk_i, .rst_ni,
    .ev_i       (ev),
    .clr_i      (sta_wr),
    .clr_mask_i (wdata_i[7:2]),
    .ien_i      (ctl_q[7:2]),
    .sta_o      (sta),
    .irq_o      (irq_o)
  );

  assign wake_o = sta[0] && ctl_q[1];

  always_comb begin
    case (addr_i)
      ADDR_W'(OFF_ID):  rdata_o = {ID_CODE, REV};
      ADDR_W'(OFF_CNT): rdata_o = tod;
      ADDR_W'(OFF_ALM): rdata_o = alm_q;
      ADDR_W'(OFF_CTL): rdata_o = ctl_q;
      ADDR_W'(OFF_STA): rdata_o = {15'b0, write_done, 8'b0, sta, 2'b0};
      ADDR_W'(OFF_TRM): rdata_o = trm_q;
      default:          rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/rtc_cal_checker.sv
module rtc_cal_checker import rtc_cal_pkg::*; #(
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              slow_tick_i,
  input logic              sel_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              write_done,
  input logic              cnt_ld,
  input logic              sec_ev,
  input logic [31:0]       ctl_q,
  input logic [31:0]       tod,
  input logic [EV_W-1:0]   sta,
  input logic              irq_o,
  input logic              wake_o
);
  logic slot_wr, sta_wr;
  assign slot_wr = sel_i && we_i &&
                   (addr_i == ADDR_W'(OFF_CNT) || addr_i == ADDR_W'(OFF_ALM) ||
                    addr_i == ADDR_W'(OFF_CTL) || addr_i == ADDR_W'(OFF_TRM));
  assign sta_wr  = sel_i && we_i && (addr_i == ADDR_W'(OFF_STA));

  AST_DONE_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_wr |=> !write_done);  // R2
  AST_DONE_RISE_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(write_done) |-> $past(slow_tick_i));  // R2
  AST_TOD_NEEDS_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slow_tick_i |=> $stable(tod));  // R3
  AST_TOD_HOLD_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctl_q[0] && !cnt_ld) |=> $stable(tod));  // R4
  AST_SEC_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_ev && tod[5:0] == 6'd59) |=> (tod[5:0] == 6'd0));  // R5
  AST_STA_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!slow_tick_i && !sta_wr) |=> $stable(sta));  // R9
  AST_IRQ_RISE_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(slow_tick_i));  // R10
  AST_WAKE_RISE_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wake_o) |-> $past(slow_tick_i));  // R11
endmodule

bind rtc_cal_top rtc_cal_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .slow_tick_i (slow_tick_i),
  .sel_i       (sel_i),
  .we_i        (we_i),
  .addr_i      (addr_i),
  .write_done  (write_done),
  .cnt_ld      (cnt_ld),
  .sec_ev      (sec_ev),
  .ctl_q       (ctl_q),
  .tod         (tod),
  .sta         (sta),
  .irq_o       (irq_o),
  .wake_o      (wake_o)
);

// File: tb/tb_rtc_cal_top.sv
`timescale 1ns/1ps
module tb_rtc_cal_top;
  localparam int HALF_DIV   = 4;
  localparam int TICK_GAP   = 3;
  localparam int DONE_BOUND = TICK_GAP + 2;
  localparam int WD_LIMIT   = 20000;
  localparam logic [7:0] REV = 8'h01;

  localparam logic [7:0] A_ID = 8'h00, A_RSV = 8'h04, A_CNT = 8'h10, A_ALM = 8'h14,
                         A_CTL = 8'h18, A_STA = 8'h1C, A_TRM = 8'h20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        sel = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, wake;

  always #10 clk = ~clk;

  rtc_cal_top #(.ADDR_W(8), .HALF_DIV(HALF_DIV), .REV(REV)) dut (
    .clk_i(clk), .rst_ni(rst_n), .slow_tick_i(tick), .sel_i(sel), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .wake_o(wake)
  );

  int    n_chk = 0, n_fail = 0, cyc = 0;
  string cur_tag = "R1";

  task automatic chk(input string tag, input bit ok, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // slow tick source
  bit tick_on = 0;
  int tgap = 0;
  always @(negedge clk) begin
    if (!rst_n || !tick_on) begin tick <= 1'b0; tgap <= 0; end
    else if (tgap == TICK_GAP - 1) begin tick <= 1'b1; tgap <= 0; end
    else begin tick <= 1'b0; tgap <= tgap + 1; end
  end

  // behavioural reference model
  int          m_sec, m_min, m_hr, m_day, m_pre;
  bit          m_ph;
  bit [31:0]   m_sh [4];
  bit          m_pend [4];
  bit [31:0]   m_alm, m_ctl, m_trm;
  bit [7:0]    m_st, m_ev, m_clr;
  bit [7:0]    OFFS [4] = '{8'h10, 8'h14, 8'h18, 8'h20};

  function automatic bit m_done();
    return !(m_pend[0] || m_pend[1] || m_pend[2] || m_pend[3]);
  endfunction

  function automatic logic [31:0] enc(int d, int h, int m, int s);
    return {d[14:0], h[4:0], m[5:0], s[5:0]};
  endfunction

  function automatic logic [31:0] exp_rd(logic [7:0] a);
    case (a)
      A_ID:  return {24'h030110, REV};
      A_CNT: return enc(m_day, m_hr, m_min, m_sec);
      A_ALM: return m_alm;
      A_CTL: return m_ctl;
      A_STA: return {15'b0, m_done(), 8'b0, m_st};
      A_TRM: return m_trm;
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sec = 0; m_min = 0; m_hr = 0; m_day = 0; m_pre = 0; m_ph = 0;
      m_alm = 0; m_ctl = 0; m_trm = 0; m_st = 0;
      for (int s = 0; s < 4; s++) begin m_sh[s] = 0; m_pend[s] = 0; end
    end else begin
      m_ev = 0;
      if (tick && m_pend[0]) begin
        m_day = m_sh[0][31:17]; m_hr = m_sh[0][16:12]; m_min = m_sh[0][11:6]; m_sec = m_sh[0][5:0];
        m_pre = 0; m_ph = 0;
      end else if (tick && m_ctl[0]) begin
        if (m_pre == HALF_DIV - 1) begin
          m_pre = 0; m_ev[7] = 1;
          if (m_ph) begin
            m_ev[6] = 1; m_sec++;
            if (m_sec == 60) begin
              m_sec = 0; m_ev[5] = 1; m_min++;
              if (m_min == 60) begin
                m_min = 0; m_ev[4] = 1; m_hr++;
                if (m_hr == 24) begin m_hr = 0; m_ev[3] = 1; m_day = (m_day + 1) % 32768; end
              end
            end
            if (m_hr == int'(m_alm[16:12]) && m_min == int'(m_alm[11:6]) && m_sec == int'(m_alm[5:0]))
              m_ev[2] = 1;
          end
          m_ph = !m_ph;
        end else m_pre++;
      end
      if (tick && m_pend[1]) m_alm = m_sh[1];
      if (tick && m_pend[2]) m_ctl = m_sh[2];
      if (tick && m_pend[3]) m_trm = m_sh[3];
      m_clr = (sel && we && addr == A_STA) ? (wdata[7:0] & 8'hFC) : 8'h0;
      m_st = (m_st & ~m_clr) | m_ev;
      for (int s = 0; s < 4; s++) begin
        if (sel && we && addr == OFFS[s]) begin
          m_sh[s] = (s == 2) ? (wdata & 32'hFF) : wdata; m_pend[s] = 1;
        end else if (tick) m_pend[s] = 0;
      end
    end
  end

  // per-cycle comparison, away from the rising edge
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      chk("R10", irq == |(m_st[7:2] & m_ctl[7:2]), 32'(irq), 32'(|(m_st[7:2] & m_ctl[7:2])));
      chk("R11", wake == (m_st[2] & m_ctl[1]), 32'(wake), 32'(m_st[2] & m_ctl[1]));
      if (sel && !we) chk(cur_tag, rdata == exp_rd(addr), rdata, exp_rd(addr));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= WD_LIMIT) begin
      n_chk++; n_fail++;
      $display("FAIL R2 watchdog actual=%0d expected<%0d", cyc, WD_LIMIT);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); sel = 1; we = 1; addr = a; wdata = d;
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    @(negedge clk); sel = 1; we = 0; addr = a; cur_tag = tag;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); sel = 0; we = 0; end
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    logic [31:0] v;
    do begin
      @(negedge clk); sel = 1; we = 0; addr = A_STA; cur_tag = tag;
      #2 v = rdata; n++;
    end while (!v[16] && n < 40);
    chk(tag, n <= DONE_BOUND, n, DONE_BOUND);  // R2 bounded return of write-done
  endtask

  initial begin
    idle(4);
    @(negedge clk); rst_n = 1;
    rd(A_ID, "R1"); rd(A_RSV, "R1"); rd(8'h3C, "R1");
    rd(A_STA, "R2"); rd(A_CTL, "R3");
    // writes with the slow domain stalled stay invisible (R3), done low (R2)
    wr(A_CNT, enc(5, 23, 59, 58));
    rd(A_STA, "R2"); rd(A_CNT, "R3");
    wr(A_TRM, 32'h0000_00A5);
    rd(A_TRM, "R3"); idle(6); rd(A_STA, "R2");
    tick_on = 1;
    wait_done("R2");
    rd(A_CNT, "R3"); rd(A_TRM, "R3");
    // alarm with nonzero day field, all enables; control upper bits dropped (R3)
    wr(A_ALM, enc(77, 0, 0, 3));
    wr(A_CTL, 32'hFFFF_FFFF);
    rd(A_CTL, "R3");
    wait_done("R2");
    rd(A_CTL, "R3"); rd(A_ALM, "R7");
    // run through the day rollover and into the alarm (R4 R5 R7 R8)
    for (int i = 0; i < 24; i++) begin
      idle(5); rd(A_CNT, "R5"); rd(A_STA, "R8");
    end
    rd(A_STA, "R7");
    // write-1-to-clear (R9)
    wr(A_STA, 32'h0); rd(A_STA, "R9");
    wr(A_STA, 32'h0000_0004); rd(A_STA, "R9");
    wr(A_STA, 32'h0000_00F8); rd(A_STA, "R9");
    // only alarm irq routed, wake off (R10 R11)
    wr(A_CTL, 32'h0000_0005);
    wait_done("R2");
    wr(A_ALM, enc(0, 0, 0, 9));
    wait_done("R2");
    for (int i = 0; i < 20; i++) begin idle(6); rd(A_STA, "R10"); end
    // wake routed again (R11)
    wr(A_CTL, 32'h0000_0007);
    wait_done("R11");
    idle(4); rd(A_STA, "R11");
    wr(A_STA, 32'h0000_00FC); rd(A_STA, "R9");
    // day count wrap (R5)
    wr(A_CNT, enc(32767, 23, 59, 59));
    wait_done("R2");
    for (int i = 0; i < 8; i++) begin idle(4); rd(A_CNT, "R5"); end
    // load mid-count restarts the divider (R6)
    idle(5);
    wr(A_CNT, enc(1, 2, 3, 4));
    for (int i = 0; i < 70; i++) rd(A_CNT, "R6");
    // disable: counter frozen (R4)
    wr(A_CTL, 32'h0);
    wait_done("R2");
    rd(A_CNT, "R4"); idle(60); rd(A_CNT, "R4"); rd(A_STA, "R4");
    idle(3);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule